// File: doc/BRIEF.md
# Energy-Balanced Series Cell Selector

This block sits between the current regulator of a semiconductor DC breaker and the gate drivers of its series cells. The regulator delivers a signed fixed-point word that asks for some number of cells to be inserted. Inserting a cell puts its surge arrester into the current path. The block turns that word into a whole number of cells, using hysteresis so that the count does not chatter around a boundary. On every switching-period strobe it picks which cells to insert. The cells chosen are the ones that have absorbed the least energy so far, which spreads the dissipation evenly across the arresters.

Each cell keeps an energy estimate. On every clock cycle in which the cell is inserted, the block adds that cell's power sample to its running sum. The sum saturates at full scale. A cell raises a flag when its sum passes a programmable trip level, so the opening sequencer can decide to give up limiting and open the breaker. A force input inserts every cell for a full opening. A status output tells the sequencer when every cell is bypassed, which means limiting has ended in the closed state.

Top module: `cell_balance_selector`

## Requirements
- R1: After a synchronous active-low reset, `insert_mask` is all zeros, `req_count` is 0, every energy sum is 0, `over_energy` is all zeros and `all_bypassed` is 1.
- R2: The controller word is signed two's complement, and one cell equals 2^FRAC_W LSBs (256 by default). Negative words are treated as 0 and words above NCELL*2^FRAC_W are treated as that value, so `req_count` always stays between 0 and NCELL.
- R3: `req_count` changes only on a cycle that carries a strobe, and takes its new value at the next edge. With held count k and clamped value v: if v >= (k+1)*2^FRAC_W the count becomes floor(v/2^FRAC_W); otherwise, if k > 0 and v <= (k-1)*2^FRAC_W, it becomes ceil(v/2^FRAC_W); otherwise it stays k.
- R4: On a strobe cycle without force, the next `insert_mask` has exactly the new count of bits set. Those bits belong to the cells with the smallest energy sums at that cycle, and on equal sums the lower cell index is preferred. Bit i of the mask drives cell i, and 1 means inserted.
- R5: On each edge, an inserted cell adds its PWR_W-bit power sample (slice i of `pwr_sample`) to its sum. A bypassed cell's sum does not change.
- R6: An energy sum saturates at 2^ENG_W-1 and never wraps.
- R7: `energy_clr` high zeroes every sum at the next edge. It takes priority over accumulation.
- R8: `over_energy[i]` is 1 exactly when cell i's sum is strictly greater than `trip_level`.
- R9: `force_all` high sets every mask bit at the next edge, with or without a strobe. After force is released, the mask holds until the next strobe.
- R10: `all_bypassed` is 1 exactly when `insert_mask` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_tick | input | 1 | One-cycle switching-period strobe |
| ctrl_word | input | CTRL_W | Signed regulator output, FRAC_W fraction bits per cell |
| force_all | input | 1 | Insert every cell (full opening) |
| pwr_sample | input | NCELL*PWR_W | Unsigned per-cell arrester power samples, cell i at slice i |
| energy_clr | input | 1 | Clear all energy sums |
| trip_level | input | ENG_W | Over-energy threshold |
| insert_mask | output | NCELL | Registered cell insert mask, 1 = arrester in circuit |
| req_count | output | CNT_W | Quantised cell count after hysteresis |
| cell_energy | output | NCELL*ENG_W | Per-cell energy sums, cell i at slice i |
| over_energy | output | NCELL | Per-cell over-energy flags |
| all_bypassed | output | 1 | Every cell bypassed |

## Verification
Every cycle, the assertions check the following. The count stays within range and holds between strobes. The mask holds between strobes unless force is applied, and force produces an all-ones mask. After a strobe, the number of inserted cells equals the count. A bypassed cell's sum stays flat, and a sum never falls unless it is cleared. Whether the selected cells really are the lowest-energy ones, the exact hysteresis thresholds, the saturation value, and the strict comparison against the trip level can only be shown by the bench. It runs directed boundary sequences and random regulator words, strobes and power samples against its own reference model.

// File: rtl/cell_sel_pkg.sv
`timescale 1ns/1ps
// Shared sizing helpers for the cell selector.
// Assumes NCELL is small (a handful of cells), so a full pairwise compare is cheap.
package cell_sel_pkg;
    // Width needed to hold a count from 0 to n inclusive.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cell_hyst_quant.sv
`timescale 1ns/1ps
// Turns a signed fixed-point regulator word into a whole cell count, with hysteresis.
// Assumes FRAC_W fraction bits per cell and that NCELL*2^FRAC_W fits in CTRL_W bits.
// The count only moves on a strobe; count_next is the value it will take.
module cell_hyst_quant #(
    parameter int NCELL  = 4,
    parameter int CTRL_W = 16,
    parameter int FRAC_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  count_next
);
    localparam int VW = CTRL_W + 1;
    localparam logic [VW-1:0] STEP_V = VW'(1 << FRAC_W);
    localparam logic [VW-1:0] FULL_V = VW'(NCELL << FRAC_W);

    logic [VW-1:0] v_clamp;
    logic [VW-1:0] up_thr;
    logic [VW-1:0] dn_thr;
    logic [VW-1:0] floor_w;
    logic [VW-1:0] ceil_w;
    logic [VW-1:0] cnt_w;

    // Clamp the signed word into the range 0 .. NCELL cells.
    always_comb begin
        if (ctrl_word[CTRL_W-1])
            v_clamp = '0;
        else if ({1'b0, ctrl_word} > FULL_V)
            v_clamp = FULL_V;
        else
            v_clamp = {1'b0, ctrl_word};
    end

    // Hysteresis band: move up only past the next whole step, down only at or below the previous one.
    always_comb begin
        cnt_w   = VW'(count_q);
        up_thr  = (cnt_w + VW'(1)) << FRAC_W;
        dn_thr  = (cnt_w - VW'(1)) << FRAC_W;
        floor_w = v_clamp >> FRAC_W;
        ceil_w  = (v_clamp + STEP_V - VW'(1)) >> FRAC_W;
        if (v_clamp >= up_thr)
            count_next = floor_w[CNT_W-1:0];
        else if ((count_q != '0) && (v_clamp <= dn_thr))
            count_next = ceil_w[CNT_W-1:0];
        else
            count_next = count_q;
    end

    // Hold the count, updating it on the switching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (tick)
            count_q <= count_next;
    end

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(NCELL));
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));
endmodule

// File: rtl/cell_energy_rank.sv
`timescale 1ns/1ps
// Chooses the `count` cells with the lowest energy sums.
// Pairwise compare: cell i's rank is the number of cells that beat it, where a lower sum
// beats a higher one and, on equal sums, a lower index wins. Purely combinational.
module cell_energy_rank #(
    parameter int NCELL = 4,
    parameter int ENG_W = 24,
    parameter int CNT_W = 3
) (
    input  logic [NCELL*ENG_W-1:0] energy,
    input  logic [CNT_W-1:0]       count,
    output logic [NCELL-1:0]       pick
);
    logic [CNT_W-1:0] rank [NCELL];

    // Count how many cells beat each cell, then keep those ranked below the count.
    always_comb begin
        for (int i = 0; i < NCELL; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NCELL; j++) begin
                if (j != i) begin
                    if ((energy[j*ENG_W +: ENG_W] < energy[i*ENG_W +: ENG_W]) ||
                        ((energy[j*ENG_W +: ENG_W] == energy[i*ENG_W +: ENG_W]) && (j < i)))
                        rank[i] = rank[i] + CNT_W'(1);
                end
            end
            pick[i] = (rank[i] < count);
        end
    end

    assert_pick_count_R4: assert final ($countones(pick) == int'(count) || int'(count) > NCELL);
endmodule

// File: rtl/cell_energy_acc.sv
`timescale 1ns/1ps
// Saturating energy sum for one cell. Adds the power sample on each clock while
// the cell is inserted, clears on request, and flags a sum above the trip level.
module cell_energy_acc #(
    parameter int PWR_W = 16,
    parameter int ENG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inserted,
    input  logic [PWR_W-1:0] pwr,
    input  logic [ENG_W-1:0] trip,
    output logic [ENG_W-1:0] energy_q,
    output logic             over
);
    logic [ENG_W:0] sum;

    // Widened sum so a carry out marks saturation.
    always_comb sum = {1'b0, energy_q} + (ENG_W+1)'(pwr);

    // Integrate while inserted; clear has priority; saturate at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)
            energy_q <= '0;
        else if (clr)
            energy_q <= '0;
        else if (inserted)
            energy_q <= sum[ENG_W] ? {ENG_W{1'b1}} : sum[ENG_W-1:0];
    end

    // Strict over-threshold flag.
    always_comb over = (energy_q > trip);

    assert_bypass_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inserted && !clr) |=> $stable(energy_q));
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (energy_q >= $past(energy_q)));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (energy_q == '0));
endmodule

// File: rtl/cell_balance_selector.sv
`timescale 1ns/1ps
// Top of the energy-balanced series cell selector.
// On each switching strobe the quantised count selects the lowest-energy cells to insert;
// force_all inserts every cell at once. Assumes period_tick is a single-cycle pulse.
module cell_balance_selector #(
    parameter int NCELL  = 4,
    parameter int CTRL_W = 16,
    parameter int FRAC_W = 8,
    parameter int PWR_W  = 16,
    parameter int ENG_W  = 24,
    parameter int CNT_W  = cell_sel_pkg::count_width(NCELL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   period_tick,
    input  logic [CTRL_W-1:0]      ctrl_word,
    input  logic                   force_all,
    input  logic [NCELL*PWR_W-1:0] pwr_sample,
    input  logic                   energy_clr,
    input  logic [ENG_W-1:0]       trip_level,
    output logic [NCELL-1:0]       insert_mask,
    output logic [CNT_W-1:0]       req_count,
    output logic [NCELL*ENG_W-1:0] cell_energy,
    output logic [NCELL-1:0]       over_energy,
    output logic                   all_bypassed
);
    logic [CNT_W-1:0] count_next;
    logic [NCELL-1:0] pick;

    cell_hyst_quant #(
        .NCELL(NCELL), .CTRL_W(CTRL_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)
    ) u_quant (
        .clk(clk), .rst_n(rst_n), .tick(period_tick), .ctrl_word(ctrl_word),
        .count_q(req_count), .count_next(count_next)
    );

    cell_energy_rank #(
        .NCELL(NCELL), .ENG_W(ENG_W), .CNT_W(CNT_W)
    ) u_rank (
        .energy(cell_energy), .count(count_next), .pick(pick)
    );

    // Register the insert mask: force wins, otherwise refresh on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            insert_mask <= '0;
        else if (force_all)
            insert_mask <= '1;
        else if (period_tick)
            insert_mask <= pick;
    end

    // One saturating energy sum per cell.
    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        cell_energy_acc #(.PWR_W(PWR_W), .ENG_W(ENG_W)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr(energy_clr), .inserted(insert_mask[g]),
            .pwr(pwr_sample[g*PWR_W +: PWR_W]), .trip(trip_level),
            .energy_q(cell_energy[g*ENG_W +: ENG_W]), .over(over_energy[g])
        );
    end

    // Sequencer status: no arrester in circuit.
    always_comb all_bypassed = (insert_mask == '0);

    assert_mask_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_tick && !force_all) |=> ($countones(insert_mask) == int'(req_count)));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_tick && !force_all) |=> $stable(insert_mask));
    assert_force_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_all |=> (&insert_mask));
endmodule

// File: tb/cell_balance_selector_tb.sv
`timescale 1ns/1ps
module cell_balance_selector_tb;
    localparam int NCELL = 4, CTRL_W = 16, FRAC_W = 8, PWR_W = 16, ENG_W = 24, CNT_W = 3;
    localparam logic [ENG_W-1:0] EMAX = {ENG_W{1'b1}};

    logic clk = 0, rst_n = 0, period_tick = 0, force_all = 0, energy_clr = 0;
    logic [CTRL_W-1:0] ctrl_word = '0;
    logic [NCELL*PWR_W-1:0] pwr_sample = '0;
    logic [ENG_W-1:0] trip_level = EMAX;
    logic [NCELL-1:0] insert_mask, over_energy;
    logic [CNT_W-1:0] req_count;
    logic [NCELL*ENG_W-1:0] cell_energy;
    logic all_bypassed;

    int checks = 0, errors = 0;
    bit done = 0;

    cell_balance_selector u_dut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .ctrl_word(ctrl_word),
        .force_all(force_all), .pwr_sample(pwr_sample), .energy_clr(energy_clr),
        .trip_level(trip_level), .insert_mask(insert_mask), .req_count(req_count),
        .cell_energy(cell_energy), .over_energy(over_energy), .all_bypassed(all_bypassed)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    logic [CNT_W-1:0] m_cnt;
    logic [NCELL-1:0] m_mask;
    logic [ENG_W-1:0] m_e [NCELL];

    function automatic logic [CNT_W-1:0] f_quant(input logic [CNT_W-1:0] k, input logic [CTRL_W-1:0] w);
        int v, sv;
        sv = $signed(w);
        v = (sv < 0) ? 0 : ((sv > NCELL*256) ? NCELL*256 : sv);
        if (v >= (int'(k) + 1) * 256) return CNT_W'(v / 256);
        if (k != 0 && v <= (int'(k) - 1) * 256) return CNT_W'((v + 255) / 256);
        return k;
    endfunction

    function automatic logic [NCELL-1:0] f_pick(input logic [CNT_W-1:0] c);
        logic [NCELL-1:0] r;
        for (int i = 0; i < NCELL; i++) begin
            int rk = 0;
            for (int j = 0; j < NCELL; j++)
                if (j != i && (m_e[j] < m_e[i] || (m_e[j] == m_e[i] && j < i))) rk++;
            r[i] = (rk < int'(c));
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_mask <= '0;
            for (int i = 0; i < NCELL; i++) m_e[i] <= '0;
        end else begin
            logic [CNT_W-1:0] nc;
            nc = period_tick ? f_quant(m_cnt, ctrl_word) : m_cnt;
            m_cnt <= nc;
            if (force_all) m_mask <= '1;
            else if (period_tick) m_mask <= f_pick(nc);
            for (int i = 0; i < NCELL; i++) begin
                if (energy_clr) m_e[i] <= '0;
                else if (m_mask[i]) begin
                    logic [ENG_W:0] s;
                    s = {1'b0, m_e[i]} + (ENG_W+1)'(pwr_sample[i*PWR_W +: PWR_W]);
                    m_e[i] <= s[ENG_W] ? EMAX : s[ENG_W-1:0];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model; call at a falling edge.
    task automatic check_all();
        chk(insert_mask == m_mask, "R4/R9 mask", insert_mask, m_mask);
        chk(req_count == m_cnt, "R3 count", req_count, m_cnt);
        chk(all_bypassed == (m_mask == 0), "R10 bypass", all_bypassed, m_mask == 0);
        for (int i = 0; i < NCELL; i++) begin
            chk(cell_energy[i*ENG_W +: ENG_W] == m_e[i], "R5 energy", cell_energy[i*ENG_W +: ENG_W], m_e[i]);
            chk(over_energy[i] == (m_e[i] > trip_level), "R8 flag", over_energy[i], m_e[i] > trip_level);
        end
    endtask

    task automatic strobe_count(input int w, input int exp, input string req);
        @(negedge clk); ctrl_word = CTRL_W'(w); period_tick = 1;
        @(negedge clk); period_tick = 0;
        chk(req_count == CNT_W'(exp), req, req_count, exp);
        chk($countones(insert_mask) == exp, "R4 popcount", $countones(insert_mask), exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(insert_mask == 0, "R1 mask", insert_mask, 0);
        chk(req_count == 0, "R1 count", req_count, 0);
        chk(cell_energy == 0, "R1 energy", 0, 0);
        chk(over_energy == 0, "R1 flag", over_energy, 0);
        chk(all_bypassed == 1, "R1 bypass", all_bypassed, 1);

        // R2 clamp and R3 hysteresis, directed
        strobe_count(200, 0, "R3 below step");
        strobe_count(256, 1, "R3 up at step");
        chk(insert_mask == 4'b0001, "R4 tie low index", insert_mask, 4'b0001);
        strobe_count(130, 1, "R3 hold in band");
        strobe_count(0, 0, "R3 down at zero");
        strobe_count(700, 2, "R3 floor jump");
        strobe_count(300, 2, "R3 hold above lower");
        strobe_count(256, 1, "R3 ceil down");
        strobe_count(-500, 0, "R2 negative clamp");
        strobe_count(5000, 4, "R2 upper clamp");

        // R6 saturation and R8 strict threshold
        @(negedge clk); pwr_sample = '1; trip_level = EMAX - 1;
        repeat (300) @(negedge clk);
        chk(cell_energy[0 +: ENG_W] == EMAX, "R6 saturate", cell_energy[0 +: ENG_W], EMAX);
        chk(over_energy == 4'hF, "R8 above trip", over_energy, 4'hF);
        trip_level = EMAX;
        @(negedge clk);
        chk(over_energy == 0, "R8 equal not over", over_energy, 0);
        // R7 clear
        energy_clr = 1;
        @(negedge clk); energy_clr = 0;
        chk(cell_energy == 0, "R7 clear", 0, 0);
        // R9 force then hold until strobe
        strobe_count(0, 0, "R3 back to zero");
        force_all = 1; pwr_sample = '0;
        @(negedge clk); force_all = 0;
        chk(insert_mask == 4'hF, "R9 force", insert_mask, 4'hF);
        @(negedge clk);
        chk(insert_mask == 4'hF, "R9 hold after force", insert_mask, 4'hF);
        chk(all_bypassed == 0, "R10 not bypassed", all_bypassed, 0);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            check_all();
            ctrl_word = CTRL_W'(int'($urandom_range(0, 1600)) - 300);
            period_tick = ($urandom_range(0, 3) == 0);
            force_all = ($urandom_range(0, 60) == 0);
            energy_clr = ($urandom_range(0, 500) == 0);
            for (int i = 0; i < NCELL; i++) pwr_sample[i*PWR_W +: PWR_W] = PWR_W'($urandom_range(0, 3000));
            if ($urandom_range(0, 20) == 0) trip_level = ENG_W'($urandom_range(0, 2000000));
        end
        @(negedge clk);
        check_all();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule